// File: doc/BRIEF.md
# Planar Video Memory Write Pipeline

This block forms the data that a four-plane display memory stores on each host write. The host byte, the 32-bit latch value (one byte per plane, plane p in bits 8p+7..8p) and a per-plane write enable go in. One cycle later, the block presents the byte for every plane, a per-plane write strobe and a valid flag.

Between those two points sit several stages: a right rotator, a per-plane substitution of a constant colour, a logic unit that combines with the latch, and a bit-wise merge against the latch. A two-bit write mode decides which stages take part and how data flows through them.

The control fields live in a small register bank inside the block. A host reaches it through an index/data pair: a write with `cfg_idx_we` loads the index, and a write with `cfg_dat_we` stores a byte into the register that the index selects. `cfg_rdata` always shows the selected register.

Top module: `planar_write_pipe`

## Requirements
- R1: A cycle with `wr_req` high produces, on the next cycle only, `out_valid`=1 and `out_strobe` equal to the `plane_en` sampled with the request. In every other cycle `out_valid` and `out_strobe` are 0. After reset, `out_valid`, `out_strobe` and `out_data` are 0.
- R2: The rotate count is in bits [2:0] of index 1. It rotates the host byte right: each step moves bit 0 into bit 7. The rotation is used in modes 0 and 3 only; in mode 2 it has no effect.
- R3: The write mode is in bits [1:0] of index 0. In mode 0, a plane whose bit in the substitution-enable register (index 3, bits [3:0]) is 1 takes its bit of the colour register (index 2, bits [3:0]) copied to all 8 bits. Every other plane takes the rotated host byte.
- R4: The logic operation is in bits [4:3] of index 1. The codes are 00 pass, 01 AND latch, 10 OR latch and 11 XOR latch. The operation acts in modes 0 and 2 and has no effect in mode 3.
- R5: The bit mask is index 4, bits [7:0]. In modes 0 and 2, a mask bit of 1 takes the logic-unit bit and a 0 takes the latch bit, at the same position in all four planes. A mask of 0x00 gives the latch in every mode.
- R6: In mode 1, `out_data` equals the latch. The host byte and all other fields have no effect.
- R7: In mode 2, host bit p (p = 0..3) is copied to all 8 bits of plane p before the logic operation.
- R8: In mode 3, every plane takes its colour-register bit copied to 8 bits. The rotated host byte ANDed with the bit mask acts as the mask against the latch.
- R9: Unused fields read as zero. Indices 5 to 15 read as 0x00, and writes to them change nothing. Bits outside a field read as 0.
- R10: After reset, the bit mask reads 0xFF and every other register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx_we | input | 1 | Load the register index from cfg_wdata[3:0] |
| cfg_dat_we | input | 1 | Store cfg_wdata into the indexed register |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Contents of the indexed register |
| wr_req | input | 1 | Host write request |
| host_byte | input | 8 | Host write data |
| latch_in | input | 32 | Latch contents, plane p in bits 8p+7..8p |
| plane_en | input | 4 | Per-plane write enable |
| out_valid | output | 1 | Result valid, one cycle after wr_req |
| out_strobe | output | 4 | Per-plane write strobe |
| out_data | output | 32 | Data to store, plane p in bits 8p+7..8p |

## Verification
The result of a write is due exactly one clock edge after the edge that samples `wr_req`. The bench drives each request at a falling edge and samples `out_data`, `out_strobe` and `out_valid` at the next falling edge. It then checks one falling edge later that valid and strobe have dropped. A register store takes effect at the edge that samples `cfg_dat_we`, and readback is combinational from the stored index. Readback checks therefore sample one falling edge after the index load, and a write that follows configuration starts only after the last store has been clocked in.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

    localparam int NPLANE  = 4;
    localparam int BYTE_W  = 8;
    localparam int DATA_W  = NPLANE * BYTE_W;
    localparam int ROT_W   = $clog2(BYTE_W);
    localparam int IDX_W   = 4;

    localparam logic [IDX_W-1:0] IDX_MODE  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_ROTOP = 4'd1;
    localparam logic [IDX_W-1:0] IDX_COLOR = 4'd2;
    localparam logic [IDX_W-1:0] IDX_SUBEN = 4'd3;
    localparam logic [IDX_W-1:0] IDX_MASK  = 4'd4;

    typedef enum logic [1:0] {
        WM_MERGE  = 2'd0,
        WM_LATCH  = 2'd1,
        WM_SPREAD = 2'd2,
        WM_STAMP  = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_AND  = 2'd1,
        OP_OR   = 2'd2,
        OP_XOR  = 2'd3
    } aluop_e;

    typedef struct packed {
        wmode_e              wmode;
        logic [ROT_W-1:0]    rot;
        aluop_e              op;
        logic [NPLANE-1:0]   color;
        logic [NPLANE-1:0]   sub_en;
        logic [BYTE_W-1:0]   mask;
    } wcfg_t;

    localparam wcfg_t CFG_RESET = '{
        wmode:  WM_MERGE,
        rot:    '0,
        op:     OP_PASS,
        color:  '0,
        sub_en: '0,
        mask:   '1
    };

    function automatic logic [BYTE_W-1:0] ror_byte(input logic [BYTE_W-1:0] b,
                                                   input logic [ROT_W-1:0]  n);
        logic [2*BYTE_W-1:0] dbl;
        dbl = {b, b} >> n;
        return dbl[BYTE_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] fill_byte(input logic bitv);
        return {BYTE_W{bitv}};
    endfunction

    function automatic logic [BYTE_W-1:0] alu_byte(input aluop_e op,
                                                   input logic [BYTE_W-1:0] a,
                                                   input logic [BYTE_W-1:0] lat);
        logic [BYTE_W-1:0] r;
        unique case (op)
            OP_AND:  r = a & lat;
            OP_OR:   r = a | lat;
            OP_XOR:  r = a ^ lat;
            default: r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwp_regfile.sv
module pwp_regfile
    import pwp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               idx_we,
    input  logic               dat_we,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [BYTE_W-1:0]  rdata,
    output logic [IDX_W-1:0]   idx,
    output wcfg_t              cfg
);

    logic [IDX_W-1:0] idx_q;
    wcfg_t            cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            cfg_q <= CFG_RESET;
        end else begin
            if (idx_we) begin
                idx_q <= wdata[IDX_W-1:0];
            end
            if (dat_we) begin
                unique case (idx_q)
                    IDX_MODE:  cfg_q.wmode  <= wmode_e'(wdata[1:0]);
                    IDX_ROTOP: begin
                        cfg_q.rot <= wdata[ROT_W-1:0];
                        cfg_q.op  <= aluop_e'(wdata[ROT_W+1:ROT_W]);
                    end
                    IDX_COLOR: cfg_q.color  <= wdata[NPLANE-1:0];
                    IDX_SUBEN: cfg_q.sub_en <= wdata[NPLANE-1:0];
                    IDX_MASK:  cfg_q.mask   <= wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (idx_q)
            IDX_MODE:  rdata[1:0]              = cfg_q.wmode;
            IDX_ROTOP: rdata[ROT_W+1:0]        = {cfg_q.op, cfg_q.rot};
            IDX_COLOR: rdata[NPLANE-1:0]       = cfg_q.color;
            IDX_SUBEN: rdata[NPLANE-1:0]       = cfg_q.sub_en;
            IDX_MASK:  rdata                   = cfg_q.mask;
            default:   rdata                   = '0;
        endcase
    end

    assign idx = idx_q;
    assign cfg = cfg_q;

endmodule

// File: rtl/pwp_datapath.sv
module pwp_datapath
    import pwp_pkg::*;
#(
    parameter int PLANES = NPLANE,
    parameter int BW     = BYTE_W
) (
    input  wcfg_t                 cfg,
    input  logic [BW-1:0]         host,
    input  logic [PLANES*BW-1:0]  latch,
    output logic [PLANES*BW-1:0]  result
);

    logic [BW-1:0] rotated;
    logic [BW-1:0] eff_mask;
    logic          use_alu;

    assign rotated = ror_byte(host, cfg.rot);
    assign use_alu = (cfg.wmode == WM_MERGE) || (cfg.wmode == WM_SPREAD);

    always_comb begin
        if (cfg.wmode == WM_STAMP) begin
            eff_mask = rotated & cfg.mask;
        end else begin
            eff_mask = cfg.mask;
        end
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [BW-1:0] lat_b;
        logic [BW-1:0] src_b;
        logic [BW-1:0] alu_b;
        logic [BW-1:0] res_b;

        assign lat_b = latch[p*BW +: BW];

        always_comb begin
            unique case (cfg.wmode)
                WM_MERGE:  src_b = cfg.sub_en[p] ? fill_byte(cfg.color[p]) : rotated;
                WM_SPREAD: src_b = fill_byte(host[p]);
                WM_STAMP:  src_b = fill_byte(cfg.color[p]);
                default:   src_b = lat_b;
            endcase
        end

        assign alu_b = use_alu ? alu_byte(cfg.op, src_b, lat_b) : src_b;

        always_comb begin
            if (cfg.wmode == WM_LATCH) begin
                res_b = lat_b;
            end else begin
                res_b = (alu_b & eff_mask) | (lat_b & ~eff_mask);
            end
        end

        assign result[p*BW +: BW] = res_b;
    end

endmodule

// File: rtl/pwp_outreg.sv
module pwp_outreg #(
    parameter int PLANES = 4,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [PLANES-1:0] en,
    input  logic [DW-1:0]     din,
    output logic              valid,
    output logic [PLANES-1:0] strobe,
    output logic [DW-1:0]     dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            strobe <= '0;
            dout   <= '0;
        end else begin
            valid  <= req;
            strobe <= req ? en : '0;
            if (req) begin
                dout <= din;
            end
        end
    end

endmodule

// File: rtl/planar_write_pipe.sv
module planar_write_pipe
    import pwp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_idx_we,
    input  logic               cfg_dat_we,
    input  logic [BYTE_W-1:0]  cfg_wdata,
    output logic [BYTE_W-1:0]  cfg_rdata,
    input  logic               wr_req,
    input  logic [BYTE_W-1:0]  host_byte,
    input  logic [DATA_W-1:0]  latch_in,
    input  logic [NPLANE-1:0]  plane_en,
    output logic               out_valid,
    output logic [NPLANE-1:0]  out_strobe,
    output logic [DATA_W-1:0]  out_data
);

    wcfg_t             cfg_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] next_data;

    pwp_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .idx_we (cfg_idx_we),
        .dat_we (cfg_dat_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .idx    (idx_q),
        .cfg    (cfg_q)
    );

    pwp_datapath #(
        .PLANES (NPLANE),
        .BW     (BYTE_W)
    ) u_path (
        .cfg    (cfg_q),
        .host   (host_byte),
        .latch  (latch_in),
        .result (next_data)
    );

    pwp_outreg #(
        .PLANES (NPLANE),
        .DW     (DATA_W)
    ) u_out (
        .clk    (clk),
        .rst    (rst),
        .req    (wr_req),
        .en     (plane_en),
        .din    (next_data),
        .valid  (out_valid),
        .strobe (out_strobe),
        .dout   (out_data)
    );

endmodule

// File: rtl/pwp_checker.sv
module pwp_checker
    import pwp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_req,
    input logic [NPLANE-1:0]  plane_en,
    input logic [DATA_W-1:0]  latch_in,
    input logic               out_valid,
    input logic [NPLANE-1:0]  out_strobe,
    input logic [DATA_W-1:0]  out_data,
    input logic [BYTE_W-1:0]  cfg_rdata,
    input logic [IDX_W-1:0]   cur_idx,
    input wmode_e             cur_mode,
    input logic [BYTE_W-1:0]  cur_mask
);

    assert_req_valid_R1: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> (out_valid && out_strobe == $past(plane_en)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> (!out_valid && out_strobe == '0));

    assert_zero_mask_latch_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_req && cur_mask == '0) |=> (out_data == $past(latch_in)));

    assert_latch_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && cur_mode == WM_LATCH) |=> (out_data == $past(latch_in)));

    assert_unused_idx_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (cur_idx > IDX_MASK) |-> (cfg_rdata == '0));

endmodule

bind planar_write_pipe pwp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_req     (wr_req),
    .plane_en   (plane_en),
    .latch_in   (latch_in),
    .out_valid  (out_valid),
    .out_strobe (out_strobe),
    .out_data   (out_data),
    .cfg_rdata  (cfg_rdata),
    .cur_idx    (idx_q),
    .cur_mode   (cfg_q.wmode),
    .cur_mask   (cfg_q.mask)
);

// File: tb/planar_write_pipe_test.sv
`timescale 1ns/1ps
module planar_write_pipe_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_idx_we, cfg_dat_we;
    logic [7:0]  cfg_wdata, cfg_rdata;
    logic        wr_req;
    logic [7:0]  host_byte;
    logic [31:0] latch_in;
    logic [3:0]  plane_en;
    logic        out_valid;
    logic [3:0]  out_strobe;
    logic [31:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;

    // shadow of programmed fields
    logic [1:0] s_mode;
    logic [2:0] s_rot;
    logic [1:0] s_op;
    logic [3:0] s_color, s_suben;
    logic [7:0] s_mask;

    always #2.5 clk = ~clk;

    planar_write_pipe uut (
        .clk(clk), .rst(rst),
        .cfg_idx_we(cfg_idx_we), .cfg_dat_we(cfg_dat_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .wr_req(wr_req), .host_byte(host_byte), .latch_in(latch_in),
        .plane_en(plane_en), .out_valid(out_valid),
        .out_strobe(out_strobe), .out_data(out_data)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // expected result computed from the requirement text
    function automatic logic [31:0] expect_data(input logic [7:0] host, input logic [31:0] lat);
        logic [15:0] dbl;
        logic [7:0]  rot, src, alu, msk, lb;
        logic [31:0] res;
        dbl = {host, host} >> s_rot;
        rot = dbl[7:0];
        msk = (s_mode == 2'd3) ? (rot & s_mask) : s_mask;
        for (int p = 0; p < 4; p++) begin
            lb = lat[p*8 +: 8];
            case (s_mode)
                2'd0: src = s_suben[p] ? {8{s_color[p]}} : rot;
                2'd2: src = {8{host[p]}};
                default: src = {8{s_color[p]}};
            endcase
            if (s_mode == 2'd0 || s_mode == 2'd2) begin
                case (s_op)
                    2'd1: alu = src & lb;
                    2'd2: alu = src | lb;
                    2'd3: alu = src ^ lb;
                    default: alu = src;
                endcase
            end else begin
                alu = src;
            end
            res[p*8 +: 8] = (s_mode == 2'd1) ? lb : ((alu & msk) | (lb & ~msk));
        end
        return res;
    endfunction

    task automatic reg_wr(input logic [3:0] idx, input logic [7:0] val);
        @(negedge clk);
        cfg_idx_we = 1'b1; cfg_wdata = {4'h0, idx};
        @(negedge clk);
        cfg_idx_we = 1'b0; cfg_dat_we = 1'b1; cfg_wdata = val;
        @(negedge clk);
        cfg_dat_we = 1'b0;
    endtask

    task automatic reg_rd_chk(input string req, input logic [3:0] idx, input logic [7:0] exp);
        @(negedge clk);
        cfg_idx_we = 1'b1; cfg_wdata = {4'h0, idx};
        @(negedge clk);
        cfg_idx_we = 1'b0;
        chk(req, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic setup(input logic [1:0] m, input logic [2:0] r, input logic [1:0] op,
                         input logic [3:0] col, input logic [3:0] sen, input logic [7:0] msk);
        s_mode = m; s_rot = r; s_op = op; s_color = col; s_suben = sen; s_mask = msk;
        reg_wr(4'd0, {6'h0, m});
        reg_wr(4'd1, {3'h0, op, r});
        reg_wr(4'd2, {4'h0, col});
        reg_wr(4'd3, {4'h0, sen});
        reg_wr(4'd4, msk);
    endtask

    // request at a falling edge, result sampled one falling edge later
    task automatic do_write(input string req, input logic [7:0] host,
                            input logic [31:0] lat, input logic [3:0] pe);
        @(negedge clk);
        wr_req = 1'b1; host_byte = host; latch_in = lat; plane_en = pe;
        @(negedge clk);
        wr_req = 1'b0;
        chk(req, out_data, expect_data(host, lat));
        chk("R1", {28'h0, out_strobe}, {28'h0, pe});
        chk("R1", {31'h0, out_valid}, 32'h1);
    endtask

    task automatic t_reset;
        chk("R1", {31'h0, out_valid}, 32'h0);
        chk("R1", {28'h0, out_strobe}, 32'h0);
        chk("R1", out_data, 32'h0);
        reg_rd_chk("R10", 4'd0, 8'h00);
        reg_rd_chk("R10", 4'd1, 8'h00);
        reg_rd_chk("R10", 4'd2, 8'h00);
        reg_rd_chk("R10", 4'd3, 8'h00);
        reg_rd_chk("R10", 4'd4, 8'hFF);
    endtask

    task automatic t_regmap;
        setup(2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF);
        reg_wr(4'd0, 8'hFF);
        reg_rd_chk("R9", 4'd0, 8'h03);
        reg_wr(4'd1, 8'hFF);
        reg_rd_chk("R9", 4'd1, 8'h1F);
        reg_wr(4'd2, 8'hFF);
        reg_rd_chk("R9", 4'd2, 8'h0F);
        reg_wr(4'd4, 8'hA5);
        for (int i = 5; i < 16; i++) begin
            reg_wr(i[3:0], 8'h5A);
            reg_rd_chk("R9", i[3:0], 8'h00);
        end
        reg_rd_chk("R9", 4'd4, 8'hA5);
        reg_rd_chk("R9", 4'd0, 8'h03);
        reg_rd_chk("R9", 4'd3, 8'h00);
    endtask

    task automatic t_rotate;
        for (int r = 0; r < 8; r++) begin
            setup(2'd0, r[2:0], 2'd0, 4'h0, 4'h0, 8'hFF);
            do_write("R2", 8'h81, 32'h0, 4'hF);
        end
        setup(2'd0, 3'd3, 2'd0, 4'h0, 4'h0, 8'hFF);
        do_write("R2", 8'h81, 32'hFFFF_FFFF, 4'hF);
        chk("R2", out_data, 32'h3030_3030);
    endtask

    task automatic t_setreset;
        setup(2'd0, 3'd0, 2'd0, 4'b0011, 4'b0101, 8'hFF);
        do_write("R3", 8'hA5, 32'h1234_5678, 4'hF);
        chk("R3", out_data, 32'hA500_A5FF);
    endtask

    task automatic t_alu;
        for (int o = 0; o < 4; o++) begin
            setup(2'd0, 3'd0, o[1:0], 4'h0, 4'h0, 8'hFF);
            do_write("R4", 8'h5A, 32'h0F0F_33CC, 4'hF);
        end
        setup(2'd0, 3'd0, 2'd3, 4'h0, 4'h0, 8'hFF);
        do_write("R4", 8'h5A, 32'h0F0F_33CC, 4'hF);
        chk("R4", out_data, 32'h5555_6996);
    endtask

    task automatic t_mask;
        setup(2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'h3C);
        do_write("R5", 8'hFF, 32'h0000_0000, 4'hF);
        chk("R5", out_data, 32'h3C3C_3C3C);
        setup(2'd2, 3'd0, 2'd2, 4'h0, 4'h0, 8'h00);
        do_write("R5", 8'h0F, 32'hDEAD_BEEF, 4'hF);
        chk("R5", out_data, 32'hDEAD_BEEF);
    endtask

    task automatic t_latch_mode;
        setup(2'd1, 3'd5, 2'd3, 4'hF, 4'hF, 8'h0F);
        do_write("R6", 8'hFF, 32'hCAFE_F00D, 4'h9);
        chk("R6", out_data, 32'hCAFE_F00D);
        do_write("R6", 8'h00, 32'h1357_9BDF, 4'h6);
        chk("R6", out_data, 32'h1357_9BDF);
    endtask

    task automatic t_spread;
        setup(2'd2, 3'd3, 2'd3, 4'h0, 4'hF, 8'hFF);
        do_write("R7", 8'hF6, 32'h0F0F_0F0F, 4'hF);
        chk("R7", out_data, 32'h0FF0_F00F);
        setup(2'd2, 3'd0, 2'd0, 4'h0, 4'h0, 8'hF0);
        do_write("R7", 8'h05, 32'h1111_1111, 4'h3);
    endtask

    task automatic t_stamp;
        setup(2'd3, 3'd1, 2'd3, 4'b1010, 4'h0, 8'hF0);
        do_write("R8", 8'h0F, 32'h0000_0000, 4'hF);
        chk("R8", out_data, 32'h8000_8000);
        setup(2'd3, 3'd0, 2'd1, 4'b0110, 4'h0, 8'hFF);
        do_write("R8", 8'h3C, 32'hFFFF_FFFF, 4'hA);
    endtask

    task automatic t_idle;
        setup(2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF);
        do_write("R1", 8'h77, 32'h0, 4'h5);
        @(negedge clk);
        chk("R1", {31'h0, out_valid}, 32'h0);
        chk("R1", {28'h0, out_strobe}, 32'h0);
        do_write("R1", 8'h11, 32'h0, 4'h0);
    endtask

    initial begin
        rst = 1'b1; cfg_idx_we = 1'b0; cfg_dat_we = 1'b0; cfg_wdata = 8'h0;
        wr_req = 1'b0; host_byte = 8'h0; latch_in = 32'h0; plane_en = 4'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regmap;
        t_rotate;
        t_setreset;
        t_alu;
        t_mask;
        t_latch_mode;
        t_spread;
        t_stamp;
        t_idle;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule